// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single transfer requests from a processor core into bus cycles on a shared 16-bit address/data bus. Four extra lines carry either the high address bits or status. Every cycle runs the fixed state sequence T1, T2, T3, then any number of wait states (TW), then T4. The shared lines carry the address in T1 and data afterwards. The four upper lines carry the high address in T1 and then status: the segment in use and the interrupt-enable flag. An active-low byte-high enable, together with address bit 0, tells devices whether the transfer is a whole word, the odd byte or the even byte.

The core presents a request: a 20-bit address, direction, memory or I/O space, word or byte size, a two-bit segment code and write data. The request is taken only while the bus is idle and no external master wants the bus. A word request at an odd address is refused, and the core must split it into two byte transfers. An external master can take the bus with a hold request. The hold is granted only between cycles, and while it is granted every output of the block is tri-stated. The reset input is expected to deassert synchronously to `clk`.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, `ad_out` carries address bits 15..0 with `ad_oe` high. `as_out` carries address bits 19..16 for a memory cycle and 0000 for an I/O cycle.
- R2: From T1 through T4, `bhe_n` is 0 when the upper byte takes part. Together with `ad_out[0]` in T1, the pair (`bhe_n`, A0) reads 00 for a whole word, 01 for an odd-address byte and 10 for an even-address byte. Outside a cycle, `bhe_n` is 1.
- R3: From T2 through T4, `as_out` carries status. Bit 3 is 0. Bit 2 is the value `ie_flag` had at the previous clock edge. Bits 1..0 are the segment code of the request (00 alternate data, 01 stack, 10 code/none, 11 data).
- R4: For a write, `ad_out` carries the write data with `ad_oe` high from T2 through T4. For a read, `ad_oe` is low from T2 through T4.
- R5: `rd_n` is 0 only in T2, T3 and TW of a read cycle. It is 1 in every other state.
- R6: `ready` is sampled at the end of T3 and of each TW. Each low sample adds one TW, and the first high sample leads to T4.
- R7: For a read, `rsp_rdata` holds `ad_in` as sampled at the end of the last T3 or TW state. `rsp_done` is high for exactly the one T4 clock.
- R8: `hold_ack` rises only after T4 or from idle, when `hold_req` is high. While it is high, `ad_oe`, `as_oe`, `bhe_oe` and `rd_oe` are all 0. It falls on the first clock edge that samples `hold_req` low.
- R9: A word request (`req_byte`=0) with `req_addr[0]`=1 raises `req_reject` for that clock and starts no cycle.
- R10: A valid request is accepted (`req_accept` high) only in idle with `hold_req` low. T1 follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | 20 | Physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| req_seg | input | 2 | Segment code shown in status |
| req_wdata | input | 16 | Write data |
| ie_flag | input | 1 | Interrupt-enable flag, shown in status |
| req_accept | output | 1 | Request taken this clock |
| req_reject | output | 1 | Odd-address word request refused |
| rsp_done | output | 1 | High in T4 of each cycle |
| rsp_rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Output enable of shared lines |
| ad_in | input | 16 | Shared lines, received value |
| as_out | output | 4 | High address / status lines |
| as_oe | output | 1 | Output enable of address/status lines |
| bhe_n | output | 1 | Byte-high enable, active low |
| bhe_oe | output | 1 | Output enable of byte-high enable |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Output enable of read strobe |
| ready | input | 1 | Device ready; low inserts wait states |
| hold_req | input | 1 | External master requests the bus |
| hold_ack | output | 1 | Bus handed to external master |

## Verification
The assertions check the properties that must hold in every cycle. They check that all outputs float while hold is acknowledged and that the read strobe never overlaps a driven shared bus. They check that hold is granted only at a cycle boundary and released right after the request drops, and that a low ready always yields a wait state. They also check that an odd-address word never reaches T1 and that done is a single-clock pulse. Some behaviour can only be shown by the bench's scenarios, which compare against a reference model on every clock. These are the exact address, status and write-data values on the lines in each T-state, the `ie_flag` value seen one clock late, read data taken from the final wait state rather than an earlier one, and the byte-enable encodings for each size and alignment.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;

  localparam int SEG_W = 2;

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic             req_io,
  input  logic             req_byte,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [DW-1:0]    req_wdata,
  input  logic             ready,
  input  logic             hold_req,
  output bus_st_e          state,
  output logic [AW-1:0]    lat_addr,
  output logic             lat_write,
  output logic             lat_io,
  output logic             lat_byte,
  output logic [SEG_W-1:0] lat_seg,
  output logic [DW-1:0]    lat_wdata,
  output logic             req_accept,
  output logic             req_reject,
  output logic             cap_en
);

  bus_st_e state_d;
  logic    odd_word;
  logic    take_req;
  logic    wait_st;

  assign odd_word   = ~req_byte & req_addr[0];
  assign take_req   = (state == ST_IDLE) & req_valid & ~hold_req;
  assign req_accept = take_req & ~odd_word;
  assign req_reject = take_req & odd_word;
  assign wait_st    = (state == ST_T3) | (state == ST_TW);
  assign cap_en     = wait_st & ready & ~lat_write;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (hold_req)        state_d = ST_HOLD;
        else if (req_accept) state_d = ST_T1;
      end
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = ready ? ST_T4 : ST_TW;
      ST_T4:   state_d = hold_req ? ST_HOLD : ST_IDLE;
      ST_HOLD: state_d = hold_req ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_write <= 1'b0;
      lat_io    <= 1'b0;
      lat_byte  <= 1'b0;
      lat_seg   <= '0;
      lat_wdata <= '0;
    end else if (req_accept) begin
      lat_addr  <= req_addr;
      lat_write <= req_write;
      lat_io    <= req_io;
      lat_byte  <= req_byte;
      lat_seg   <= req_seg;
      lat_wdata <= req_wdata;
    end
  end

  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_HOLD) |-> ($past(state) == ST_IDLE || $past(state) == ST_T4)); // R8
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state == ST_HOLD) |-> !$past(hold_req)); // R8
  AST_WAIT_ON_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_st && !ready) |=> state == ST_TW); // R6
  AST_NO_ODD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T1) |-> (lat_byte || !lat_addr[0])); // R9
  AST_ACCEPT_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> state == ST_T1); // R10

endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_st_e          state,
  input  logic [AW-1:0]    lat_addr,
  input  logic             lat_write,
  input  logic             lat_io,
  input  logic             lat_byte,
  input  logic [SEG_W-1:0] lat_seg,
  input  logic [DW-1:0]    lat_wdata,
  input  logic             cap_en,
  input  logic             ie_flag,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] as_out,
  output logic             as_oe,
  output logic             bhe_n,
  output logic             bhe_oe,
  output logic             rd_n,
  output logic             rd_oe,
  output logic             hold_ack,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata
);

  localparam int HW = AW - DW;

  logic          ie_q;
  logic          in_t1;
  logic          in_mid;
  logic          strobe_st;
  logic [HW-1:0] status_w;

  assign in_t1     = (state == ST_T1);
  assign in_mid    = (state == ST_T2) | (state == ST_T3) | (state == ST_TW) | (state == ST_T4);
  assign strobe_st = (state == ST_T2) | (state == ST_T3) | (state == ST_TW);
  assign status_w  = HW'({ie_q, lat_seg});

  assign hold_ack = (state == ST_HOLD);
  assign as_oe    = ~hold_ack;
  assign bhe_oe   = ~hold_ack;
  assign rd_oe    = ~hold_ack;
  assign rsp_done = (state == ST_T4);

  always_comb begin
    ad_oe  = 1'b0;
    ad_out = '0;
    as_out = '0;
    if (in_t1) begin
      ad_oe  = 1'b1;
      ad_out = lat_addr[DW-1:0];
      as_out = lat_io ? '0 : lat_addr[AW-1:DW];
    end else if (in_mid) begin
      ad_oe  = lat_write;
      ad_out = lat_write ? lat_wdata : '0;
      as_out = status_w;
    end
  end

  assign bhe_n = (in_t1 | in_mid) ? (lat_byte & ~lat_addr[0]) : 1'b1;
  assign rd_n  = ~(strobe_st & ~lat_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_q <= 1'b0;
    else        ie_q <= ie_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (cap_en) rsp_rdata <= ad_in;
  end

  AST_FLOAT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !(ad_oe || as_oe || bhe_oe || rd_oe)); // R8
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R7

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic             req_io,
  input  logic             req_byte,
  input  logic [1:0]       req_seg,
  input  logic [DW-1:0]    req_wdata,
  input  logic             ie_flag,
  output logic             req_accept,
  output logic             req_reject,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] as_out,
  output logic             as_oe,
  output logic             bhe_n,
  output logic             bhe_oe,
  output logic             rd_n,
  output logic             rd_oe,
  input  logic             ready,
  input  logic             hold_req,
  output logic             hold_ack
);

  bus_st_e          state;
  logic [AW-1:0]    lat_addr;
  logic             lat_write;
  logic             lat_io;
  logic             lat_byte;
  logic [SEG_W-1:0] lat_seg;
  logic [DW-1:0]    lat_wdata;
  logic             cap_en;

  mbs_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_io(req_io), .req_byte(req_byte), .req_seg(req_seg), .req_wdata(req_wdata),
    .ready(ready), .hold_req(hold_req),
    .state(state), .lat_addr(lat_addr), .lat_write(lat_write), .lat_io(lat_io),
    .lat_byte(lat_byte), .lat_seg(lat_seg), .lat_wdata(lat_wdata),
    .req_accept(req_accept), .req_reject(req_reject), .cap_en(cap_en)
  );

  mbs_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state),
    .lat_addr(lat_addr), .lat_write(lat_write), .lat_io(lat_io), .lat_byte(lat_byte),
    .lat_seg(lat_seg), .lat_wdata(lat_wdata), .cap_en(cap_en),
    .ie_flag(ie_flag), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .as_oe(as_oe),
    .bhe_n(bhe_n), .bhe_oe(bhe_oe), .rd_n(rd_n), .rd_oe(rd_oe),
    .hold_ack(hold_ack), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_io, req_byte;
  logic [19:0] req_addr;
  logic [1:0]  req_seg;
  logic [15:0] req_wdata;
  logic        ie_flag;
  logic        req_accept, req_reject, rsp_done;
  logic [15:0] rsp_rdata, ad_out, ad_in;
  logic        ad_oe, as_oe, bhe_n, bhe_oe, rd_n, rd_oe, ready, hold_req, hold_ack;
  logic [3:0]  as_out;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int wcnt = 0;
  bit running = 0;

  // reference model: phase 0 idle, 1..4 = T1..T4, 5 = TW, 6 = hold
  int          m_ph = 0;
  logic [19:0] m_addr = '0;
  logic        m_wr = 0, m_io = 0, m_byte = 0, m_ie = 0;
  logic [1:0]  m_seg = '0;
  logic [15:0] m_wd = '0, m_rd = '0;

  mux_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_io(req_io), .req_byte(req_byte), .req_seg(req_seg),
    .req_wdata(req_wdata), .ie_flag(ie_flag), .req_accept(req_accept),
    .req_reject(req_reject), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .as_out(as_out), .as_oe(as_oe),
    .bhe_n(bhe_n), .bhe_oe(bhe_oe), .rd_n(rd_n), .rd_oe(rd_oe), .ready(ready),
    .hold_req(hold_req), .hold_ack(hold_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit ok_word(input logic b, input logic [19:0] a);
    return b || !a[0];
  endfunction

  // model update and per-clock comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ie = 0; m_rd = '0;
    end else begin
      case (m_ph)
        0: if (hold_req) m_ph = 6;
           else if (req_valid && ok_word(req_byte, req_addr)) begin
             m_addr = req_addr; m_wr = req_write; m_io = req_io; m_byte = req_byte;
             m_seg = req_seg; m_wd = req_wdata; m_ph = 1;
           end
        1: m_ph = 2;
        2: m_ph = 3;
        3, 5: if (ready) begin
             if (!m_wr) m_rd = ad_in;
             m_ph = 4;
           end else m_ph = 5;
        4: m_ph = hold_req ? 6 : 0;
        default: m_ph = hold_req ? 6 : 0;
      endcase
      m_ie = ie_flag;
    end
    #2;
    if (running) compare();
  end

  task automatic compare();
    bit hold, t1, mid, strobe, e_oe, e_acc, e_rej;
    logic [3:0] e_as;
    logic [15:0] e_ad;
    hold   = (m_ph == 6);
    t1     = (m_ph == 1);
    mid    = (m_ph >= 2 && m_ph <= 5);
    strobe = (m_ph == 2 || m_ph == 3 || m_ph == 5) && !m_wr;
    e_acc  = (m_ph == 0) && req_valid && !hold_req && ok_word(req_byte, req_addr);
    e_rej  = (m_ph == 0) && req_valid && !hold_req && !ok_word(req_byte, req_addr);
    e_oe   = t1 || (mid && m_wr);
    e_ad   = t1 ? m_addr[15:0] : m_wd;
    e_as   = t1 ? (m_io ? 4'h0 : m_addr[19:16]) : (mid ? {1'b0, m_ie, m_seg} : 4'h0);
    chk(ad_oe == e_oe, "R4 ad_oe", 32'(ad_oe), 32'(e_oe));
    if (e_oe) chk(ad_out == e_ad, t1 ? "R1 ad_out address" : "R4 ad_out write data", 32'(ad_out), 32'(e_ad));
    if (!hold) chk(as_out == e_as, t1 ? "R1 as_out address" : "R3 as_out status", 32'(as_out), 32'(e_as));
    chk(bhe_n == ((t1 || mid) ? (m_byte & ~m_addr[0]) : 1'b1), "R2 bhe_n", 32'(bhe_n),
        32'((t1 || mid) ? (m_byte & ~m_addr[0]) : 1'b1));
    chk(rd_n == !strobe, "R5 rd_n", 32'(rd_n), 32'(!strobe));
    chk(hold_ack == hold, "R8 hold_ack", 32'(hold_ack), 32'(hold));
    chk({as_oe, bhe_oe, rd_oe} == {3{!hold}}, "R8 output enables", 32'({as_oe, bhe_oe, rd_oe}), 32'({3{!hold}}));
    chk(rsp_done == (m_ph == 4), "R6 done timing", 32'(rsp_done), 32'(m_ph == 4));
    if (m_ph == 4 && !m_wr) chk(rsp_rdata == m_rd, "R7 read data", 32'(rsp_rdata), 32'(m_rd));
    chk(req_accept == e_acc, "R10 req_accept", 32'(req_accept), 32'(e_acc));
    chk(req_reject == e_rej, "R9 req_reject", 32'(req_reject), 32'(e_rej));
  endtask

  // device side: ready with programmed wait count, changing read data
  always @(negedge clk) begin
    cyc++;
    ad_in = 16'hC3A5 ^ 16'(cyc * 257);
    if ((m_ph == 3 || m_ph == 5) && wcnt > 0) begin
      ready = 1'b0;
      wcnt--;
    end else ready = 1'b1;
  end

  task automatic run_cyc(input logic [19:0] a, input logic w, input logic io, input logic b,
                         input logic [1:0] s, input logic [15:0] d, input int nw);
    @(negedge clk);
    req_addr = a; req_write = w; req_io = io; req_byte = b; req_seg = s; req_wdata = d;
    wcnt = nw; req_valid = 1'b1;
    @(negedge clk);
    while (m_ph == 0 || m_ph == 6) @(negedge clk);
    req_valid = 1'b0;
    while (m_ph != 0 && m_ph != 6) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; req_write = 0; req_io = 0; req_byte = 0;
    req_seg = '0; req_wdata = '0; ie_flag = 0; hold_req = 0; ready = 1; ad_in = '0;
    repeat (3) @(negedge clk);
    // reset state
    chk(hold_ack == 0, "R8 reset hold_ack", 32'(hold_ack), 0);
    chk(rsp_done == 0, "R7 reset done", 32'(rsp_done), 0);
    chk(ad_oe == 0 && rd_n == 1 && bhe_n == 1, "R5 reset strobes", 32'({ad_oe, rd_n, bhe_n}), 32'(3'b011));
    rst_n = 1;
    running = 1;
    // R1 R2 R5 R7: memory word read, even address, no waits
    run_cyc(20'hA1234, 0, 0, 0, 2'b10, 16'h0, 0);
    // R4 R6: odd byte write with two waits, ie set
    ie_flag = 1;
    run_cyc(20'h5F00F, 1, 0, 1, 2'b01, 16'hBEEF, 2);
    // R1 R3: I/O even byte read, one wait, ie toggling during the cycle
    fork
      run_cyc(20'h70456, 0, 1, 1, 2'b11, 16'h0, 1);
      begin repeat (3) begin @(negedge clk); ie_flag = ~ie_flag; end end
    join
    // R7: read with three waits, data taken at last TW
    run_cyc(20'h00002, 0, 0, 0, 2'b00, 16'h0, 3);
    // R9: odd-address word refused
    @(negedge clk);
    req_addr = 20'h12345; req_byte = 0; req_write = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    // R8 R10: hold from idle blocks a pending request
    hold_req = 1;
    @(negedge clk);
    req_addr = 20'h00010; req_byte = 0; req_valid = 1;
    repeat (4) @(negedge clk);
    hold_req = 0;
    @(negedge clk);
    while (m_ph != 0) @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    // R8: hold raised mid-cycle waits for T4
    fork
      run_cyc(20'hFFFFE, 1, 0, 0, 2'b11, 16'h1357, 1);
      begin @(negedge clk); @(negedge clk); hold_req = 1; end
    join
    repeat (3) @(negedge clk);
    hold_req = 0;
    repeat (3) @(negedge clk);
    running = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule